// File: doc/BRIEF.md
# Byte-Lane Load/Store Data Memory

A 4096-byte read/write data memory for a 64-bit integer core. Each cycle it takes a byte address, a two-bit access size, an unsigned-load flag, a write enable and 64 bits of write data. A store writes 1, 2, 4 or 8 consecutive bytes from the low end of the write data. A load returns the same widths. The value is sign-extended to 64 bits by default, or zero-extended when the unsigned flag is set. Multi-byte values are laid out little-endian.

Storage is split into eight one-byte-wide banks, one per byte lane, so that each bank maps onto a simple block RAM. A request at any byte offset touches at most one row in each bank. This holds even when the access crosses an eight-byte boundary or wraps past the top of the 4 KB range. Load data is registered inside the banks and then rotated and extended, so it is available one clock after the request.

Top module: `byte_lane_dmem`

## Requirements
- R1: Only address bits 11:0 select a byte. Addresses that differ only above bit 11 reach the same byte, so the 4096-byte space wraps.
- R2: Byte order is little-endian. Byte `addr+i` of an access holds bits `8i+7:8i` of the write data or load value.
- R3: Size code 0 stores 1 byte, code 1 stores 2, code 2 stores 4 and code 3 stores 8, all taken from the low bits of `wdata`. Bytes outside the stored width keep their contents.
- R4: With `zext` = 0, loads of size 0, 1 and 2 copy bit 7, 15 or 31 of the loaded value into every higher bit of `rdata`.
- R5: With `zext` = 1, loads of size 0, 1 and 2 clear every bit of `rdata` above the loaded width. A size-3 load returns all 64 bits regardless of `zext`.
- R6: `rdata` presents the load for the request sampled at the previous rising edge. It shows the memory contents from before any store made at that same edge.
- R7: Accesses need no alignment. An access covers consecutive byte addresses, crosses eight-byte boundaries, and wraps from 0xFFF to 0x000.
- R8: After a rising edge at which `rst` is high, `rdata` is zero. Reset leaves the stored bytes unchanged.
- R9: When `we` is 0, no byte changes, whatever `wdata`, `size` and `addr` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the load output |
| addr | input | 64 | Byte address of the access |
| size | input | 2 | Access width: 0 byte, 1 half, 2 word, 3 double |
| zext | input | 1 | 1 = zero-extend the load, 0 = sign-extend |
| we | input | 1 | Store enable |
| wdata | input | 64 | Store data, low bytes used |
| rdata | output | 64 | Load data, one cycle after the request |

## Verification
The hardest case to reach is a misaligned access that straddles two rows and also wraps past the top of memory. In that case lanes below the start offset must use the following row, and that row index itself wraps to zero. Directed stores and loads at 0xFFD and 0xFFE reach this case, and a long run of random addresses and sizes covers the other offset and width combinations. A store and a load of the same bytes in one cycle are also issued, to check that the load returns the old contents.

// File: rtl/lsram_pkg.sv
package lsram_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsram_byte_bank.sv
module lsram_byte_bank #(
  parameter int ROW_AW = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_AW-1:0] row,
  input  logic [7:0]        wd,
  output logic [7:0]        q
);
  localparam int ROWS = 1 << ROW_AW;
  logic [7:0] store [ROWS];

  // read-before-write single port: maps to one block RAM port
  always_ff @(posedge clk) begin
    if (we) store[row] <= wd;
    q <= store[row];
  end
endmodule

// File: rtl/lsram_lane_router.sv
module lsram_lane_router #(
  parameter int LANES  = 8,
  parameter int ROW_AW = 9
) (
  input  logic [ROW_AW+$clog2(LANES)-1:0]   base,
  input  logic [1:0]                        size,
  input  logic                              we,
  input  logic [8*LANES-1:0]                wdata,
  output logic [LANES-1:0][ROW_AW-1:0]      lane_row,
  output logic [LANES-1:0]                  lane_we,
  output logic [LANES-1:0][7:0]             lane_wd,
  output logic [$clog2(LANES):0]            nbytes
);
  localparam int LANE_AW = $clog2(LANES);

  logic [LANE_AW-1:0] off;
  logic [ROW_AW-1:0]  row;

  assign off    = base[LANE_AW-1:0];
  assign row    = base[ROW_AW+LANE_AW-1:LANE_AW];
  assign nbytes = (LANE_AW+1)'(1) << size;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      logic [LANE_AW-1:0] k;
      k           = LANE_AW'(l) - off;
      lane_row[l] = (LANE_AW'(l) < off) ? row + ROW_AW'(1) : row;
      lane_we[l]  = we && ({1'b0, k} < nbytes);
      lane_wd[l]  = wdata[8*k +: 8];
    end
  end
endmodule

// File: rtl/lsram_load_align.sv
module lsram_load_align #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0][7:0]     q,
  input  logic [$clog2(LANES)-1:0]  off,
  input  logic [1:0]                size,
  input  logic                      zext,
  output logic [8*LANES-1:0]        data
);
  import lsram_pkg::*;
  localparam int LANE_AW = $clog2(LANES);
  localparam int DW      = 8 * LANES;

  logic [DW-1:0] raw;

  always_comb begin
    for (int k = 0; k < LANES; k++)
      raw[8*k +: 8] = q[LANE_AW'(off + LANE_AW'(k))];
  end

  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: data = zext ? {{(DW-8){1'b0}}, raw[7:0]}
                           : {{(DW-8){raw[7]}}, raw[7:0]};
      SZ_HALF: data = zext ? {{(DW-16){1'b0}}, raw[15:0]}
                           : {{(DW-16){raw[15]}}, raw[15:0]};
      SZ_WORD: data = zext ? {{(DW-32){1'b0}}, raw[31:0]}
                           : {{(DW-32){raw[31]}}, raw[31:0]};
      default: data = raw;
    endcase
  end
endmodule

// File: rtl/byte_lane_dmem.sv
module byte_lane_dmem #(
  parameter int DEPTH_BYTES = 4096,
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              zext,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import lsram_pkg::*;
  localparam int LANES   = DATA_W / 8;
  localparam int LANE_AW = $clog2(LANES);
  localparam int BYTE_AW = $clog2(DEPTH_BYTES);
  localparam int ROW_AW  = BYTE_AW - LANE_AW;

  logic [BYTE_AW-1:0]            base;
  logic [LANES-1:0][ROW_AW-1:0]  lane_row;
  logic [LANES-1:0]              lane_we;
  logic [LANES-1:0][7:0]         lane_wd;
  logic [LANES-1:0][7:0]         lane_q;
  logic [LANE_AW:0]              nbytes;
  logic [DATA_W-1:0]             aligned;

  logic [LANE_AW-1:0] off_q;
  logic [1:0]         size_q;
  logic               zext_q;
  logic               live_q;

  assign base = addr[BYTE_AW-1:0];

  lsram_lane_router #(.LANES(LANES), .ROW_AW(ROW_AW)) u_router (
    .base(base), .size(size), .we(we), .wdata(wdata),
    .lane_row(lane_row), .lane_we(lane_we), .lane_wd(lane_wd), .nbytes(nbytes)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_bank
    lsram_byte_bank #(.ROW_AW(ROW_AW)) u_bank (
      .clk(clk), .we(lane_we[l]), .row(lane_row[l]),
      .wd(lane_wd[l]), .q(lane_q[l])
    );

    // R7: a lane touches the start row or the one after it (wrapping)
    assert_lane_row_span_R7: assert property (@(posedge clk) disable iff (rst)
      (lane_row[l] == base[BYTE_AW-1:LANE_AW]) ||
      (lane_row[l] == base[BYTE_AW-1:LANE_AW] + ROW_AW'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      size_q <= '0;
      zext_q <= 1'b0;
      live_q <= 1'b0;
    end else begin
      off_q  <= base[LANE_AW-1:0];
      size_q <= size;
      zext_q <= zext;
      live_q <= 1'b1;
    end
  end

  lsram_load_align #(.LANES(LANES)) u_align (
    .q(lane_q), .off(off_q), .size(size_q), .zext(zext_q), .data(aligned)
  );

  assign rdata = live_q ? aligned : '0;

  // R3: a store enables exactly as many lanes as its width
  assert_store_lane_count_R3: assert property (@(posedge clk) disable iff (rst)
    we |-> ($countones(lane_we) == int'(nbytes)));

  // R9: no lane is written without a store request
  assert_no_write_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !we |-> (lane_we == '0));

  // R8: reset clears the load output
  assert_reset_zero_out_R8: assert property (@(posedge clk)
    rst |=> (rdata == '0));

  // R4: signed byte loads replicate bit 7
  assert_sign_fill_byte_R4: assert property (@(posedge clk) disable iff (rst)
    (live_q && size_q == SZ_BYTE && !zext_q) |->
      (rdata[DATA_W-1:8] == {(DATA_W-8){rdata[7]}}));

  // R5: unsigned word loads clear the upper half
  assert_zero_fill_word_R5: assert property (@(posedge clk) disable iff (rst)
    (live_q && size_q == SZ_WORD && zext_q) |->
      (rdata[DATA_W-1:32] == '0));
endmodule

// File: tb/sim_byte_lane_dmem.sv
module sim_byte_lane_dmem;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] addr = '0;
  logic [1:0]  size = '0;
  logic        zext = 1'b0;
  logic        we = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;

  int total = 0;
  int fails = 0;
  logic [7:0] ref_mem [4096];

  always #4 clk = ~clk;

  byte_lane_dmem u0 (
    .clk(clk), .rst(rst), .addr(addr), .size(size), .zext(zext),
    .we(we), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [63:0] ref_load(int a, int sz, bit zx);
    int n = 1 << sz;
    logic [63:0] v = '0;
    for (int k = 0; k < n; k++) v[8*k +: 8] = ref_mem[(a + k) & 4095];
    if (!zx && n < 8 && v[8*n-1]) v = v | ~((64'd1 << (8*n)) - 64'd1);
    return v;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one request per cycle; result compared one edge later (R6 timing)
  task automatic step(logic [63:0] a, int sz, bit zx, bit w,
                      logic [63:0] d, string tag, bit chk = 1'b1);
    logic [63:0] exp;
    int n = 1 << sz;
    addr = a; size = 2'(sz); zext = zx; we = w; wdata = d;
    exp = ref_load(int'(a[11:0]), sz, zx);
    if (w) for (int k = 0; k < n; k++)
      ref_mem[(int'(a[11:0]) + k) & 4095] = d[8*k +: 8];
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    if (chk) check(tag, rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset output", rdata, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < 512; i++) begin
      logic [63:0] d;
      for (int b = 0; b < 8; b++) d[8*b +: 8] = 8'((i * 8 + b) * 37 + 11);
      step(64'(i * 8), 3, 1'b0, 1'b1, d, "init", 1'b0);
    end
    step(64'h0, 3, 1'b0, 1'b0, '0, "R3 init readback");

    // R2 little-endian placement
    step(64'h40, 3, 1'b0, 1'b1, 64'h8877665544332211, "R2 store");
    step(64'h40, 0, 1'b1, 1'b0, '0, "R2 low byte 0x11");
    step(64'h47, 0, 1'b1, 1'b0, '0, "R2 high byte 0x88");
    step(64'h42, 1, 1'b1, 1'b0, '0, "R2 half 0x4433");
    step(64'h40, 3, 1'b0, 1'b0, '0, "R2 double");

    // R3 partial stores leave neighbours alone
    step(64'h80, 0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFAA, "R3 sb");
    step(64'h80, 3, 1'b0, 1'b0, '0, "R3 sb neighbours");
    step(64'h8A, 1, 1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0, "R3 sh");
    step(64'h88, 3, 1'b0, 1'b0, '0, "R3 sh neighbours");
    step(64'h94, 2, 1'b0, 1'b1, 64'hCAFE_F00D_0BAD_BEEF, "R3 sw");
    step(64'h90, 3, 1'b0, 1'b0, '0, "R3 sw neighbours");

    // R4 sign extension
    step(64'h100, 0, 1'b0, 1'b1, 64'h80, "R4 setup b");
    step(64'h100, 0, 1'b0, 1'b0, '0, "R4 lb 0x80");
    step(64'h108, 1, 1'b0, 1'b1, 64'h8001, "R4 setup h");
    step(64'h108, 1, 1'b0, 1'b0, '0, "R4 lh 0x8001");
    step(64'h110, 2, 1'b0, 1'b1, 64'h8000_0002, "R4 setup w");
    step(64'h110, 2, 1'b0, 1'b0, '0, "R4 lw 0x80000002");
    step(64'h118, 0, 1'b0, 1'b1, 64'h7F, "R4 setup pos");
    step(64'h118, 0, 1'b0, 1'b0, '0, "R4 lb positive");

    // R5 zero extension
    step(64'h100, 0, 1'b1, 1'b0, '0, "R5 lbu");
    step(64'h108, 1, 1'b1, 1'b0, '0, "R5 lhu");
    step(64'h110, 2, 1'b1, 1'b0, '0, "R5 lwu");
    step(64'h108, 3, 1'b1, 1'b0, '0, "R5 ld with zext");

    // R6 same-cycle store returns old contents, next load the new
    step(64'h200, 3, 1'b0, 1'b1, 64'h0123_4567_89AB_CDEF, "R6 read-before-write");
    step(64'h200, 3, 1'b0, 1'b0, '0, "R6 new value");

    // R7 misaligned, boundary crossing, top wrap
    step(64'h205, 3, 1'b0, 1'b0, '0, "R7 ld crossing row");
    step(64'h20B, 3, 1'b0, 1'b1, 64'hA1B2_C3D4_E5F6_0718, "R7 sd misaligned");
    step(64'h208, 3, 1'b0, 1'b0, '0, "R7 row below");
    step(64'h210, 3, 1'b0, 1'b0, '0, "R7 row above");
    step(64'hFFD, 3, 1'b0, 1'b1, 64'h1122_3344_5566_7788, "R7 sd wrapping");
    step(64'h000, 3, 1'b0, 1'b0, '0, "R7 wrapped low bytes");
    step(64'hFF8, 3, 1'b0, 1'b0, '0, "R7 top row");
    step(64'hFFE, 2, 1'b1, 1'b0, '0, "R7 lwu wrapping");

    // R1 upper address bits ignored
    step(64'h1000_0000_0000_1310, 3, 1'b0, 1'b1, 64'h5A5A_0F0F_A5A5_F0F0, "R1 alias store");
    step(64'h310, 3, 1'b0, 1'b0, '0, "R1 alias read");
    step(64'hFFFF_FFFF_FFFF_F310, 1, 1'b1, 1'b0, '0, "R1 alias read high");

    // R9 idle cycles never write
    addr = 64'h320; size = 2'd3; zext = 1'b0; we = 1'b0; wdata = 64'hDEAD_DEAD_DEAD_DEAD;
    @(posedge clk); @(negedge clk);
    step(64'h320, 3, 1'b0, 1'b0, '0, "R9 no write");

    // R8 reset mid-run: output zero, contents kept
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 reset zero", rdata, 64'd0);
    rst = 1'b0;
    step(64'h40, 3, 1'b0, 1'b0, '0, "R8 contents kept");

    // random mix of widths, offsets and extension
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] d = {$urandom, $urandom};
      step(a, int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom_range(0, 2) == 0),
           d, "R6 random access");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule